// File: doc/BRIEF.md
# Ring Slave Time Alignment Unit

This unit runs on a slave node of a one-way control ring. It keeps a local time counter with one count per 10 ns clock cycle, which is one count per 100 MHz cycle. It aligns that counter to the master's time. Every decoded ring message that enters the node leaves it again one cycle later. Two message kinds act on the node on their way through.

At start-up an enumeration message goes round the ring. Its payload is a running counter. The node takes the incoming value as its own device number and forwards the message with the counter raised by one. The last node therefore hands the master the total slave count.

Later, time messages carry the master's time stamp. The node adds the path delay for its own place on the ring. That delay is a fixed base value plus a per-node pass-through delay multiplied by the device number. The node then compares the result with its local counter:

- A large difference is loaded into the counter in one step.
- A small difference is worked off one tick at a time, at a fixed spacing.
- The small difference is also summed into a learned rate trim. The trim keeps adding or removing ticks between time messages, so that a steady frequency error between the two oscillators is cancelled.

A watchdog drops the in-sync flag when time messages stop arriving.

Top module: `slave_time_align`

## Requirements
- R1: While reset is asserted, `local_time` is 0 and `tx_valid`, `dev_id_valid` and `in_sync` are 0.
- R2: A valid message of kind 1 (enumerate) sets `dev_id` to the low `ID_W` bits of its payload and sets `dev_id_valid`, both visible one cycle later. A later enumeration overwrites the number. `dev_id_valid` never falls outside reset.
- R3: Every valid input message appears on `tx_*` exactly one cycle later with the same kind. An enumerate payload is forwarded plus one, modulo 2^TIME_W. All other payloads are forwarded unchanged.
- R4: With no pending correction, zero rate trim and no accepted time message, `local_time` rises by exactly 1 per cycle.
- R5: A valid message of kind 2 (time) is accepted only when `dev_id_valid` is 1. The expected time is stamp + BASE_DLY + NODE_DLY * dev_id. The offset is the expected time minus `local_time`, taken as a signed TIME_W-bit difference. If |offset| > THRESH, the next `local_time` is the expected time + 1, the pending correction is cleared and the rate trim is kept.
- R6: An accepted time message with |offset| <= THRESH advances `local_time` by exactly 1 in that cycle and stores the offset as a pending correction. The pending correction is then applied one tick at a time, every SLEW_GAP cycles, until it is zero. Each step adds an extra tick for a positive correction and skips a tick for a negative one. The first step lands on the SLEW_GAP-th edge after the message.
- R7: On such a small-offset message, the rate trim gains the offset and is clamped to ±MAX_TRIM. In every cycle without an accepted message, the trim magnitude is added to an accumulator, which is cleared on each accepted message. Each time the accumulator reaches PERIOD, one tick is added (positive trim) or skipped (negative trim). A trim of T therefore yields |T| extra or skipped ticks per PERIOD cycles.
- R8: A time message that arrives before any enumeration changes neither `local_time` nor `in_sync`.
- R9: `in_sync` goes to 1 one cycle after an accepted time message. It returns to 0 on the LOSS_PERIODS*PERIOD-th edge after the last accepted message when no other message has been accepted in between.
- R10: Messages of kind 0 and 3 are only forwarded. They leave `local_time`, `dev_id` and `in_sync` untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Node clock, one time count per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Decoded message present this cycle |
| rx_kind | input | 2 | 0 data, 1 enumerate, 2 time, 3 auxiliary |
| rx_payload | input | TIME_W | Message payload: node counter or master stamp |
| tx_valid | output | 1 | Forwarded message present |
| tx_kind | output | 2 | Kind of forwarded message |
| tx_payload | output | TIME_W | Forwarded payload |
| local_time | output | TIME_W | Aligned local time count |
| dev_id | output | ID_W | Device number claimed during enumeration |
| dev_id_valid | output | 1 | A device number has been claimed |
| in_sync | output | 1 | A time message was accepted within the loss window |

## Verification
Each result of this block has its own due cycle:

- The forwarded message and the claimed device number appear on the first rising edge after the input message.
- A counter load, or the single-step advance on a small offset, is also due on that first edge.
- Slew ticks fall on the SLEW_GAP-th edge after a time message and every SLEW_GAP edges after that.
- Rate-trim ticks fall on the edges where the accumulated trim reaches PERIOD.
- The loss flag falls exactly LOSS_PERIODS*PERIOD edges after the last accepted message.

The bench advances a behavioural model on each rising edge from the same inputs. It compares every output at the following falling edge, so each of these due cycles is checked on the exact edge. Directed checks count the edges from the message to fix the exact values: `local_time` one edge after a load, one tick early on the slew edge, and the trim over a full PERIOD.

// File: rtl/tsync_pkg.sv
package tsync_pkg;

  typedef enum logic [1:0] {
    MSG_DATA = 2'd0,
    MSG_ENUM = 2'd1,
    MSG_SYNC = 2'd2,
    MSG_AUX  = 2'd3
  } msg_kind_e;

  // Saturate a signed value to +/- lim.
  function automatic int clamp_sym(input int v, input int lim);
    if (v > lim)       return lim;
    else if (v < -lim) return -lim;
    else               return v;
  endfunction

endpackage

// File: rtl/ring_fwd_stage.sv
module ring_fwd_stage
  import tsync_pkg::*;
#(
  parameter int TIME_W = 32,
  parameter int ID_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [1:0]        rx_kind,
  input  logic [TIME_W-1:0] rx_payload,
  output logic              tx_valid,
  output logic [1:0]        tx_kind,
  output logic [TIME_W-1:0] tx_payload,
  output logic [ID_W-1:0]   dev_id,
  output logic              id_valid
);

  logic enum_hit;
  assign enum_hit = rx_valid && (rx_kind == MSG_ENUM);

  function automatic logic [TIME_W-1:0] next_count(input logic [TIME_W-1:0] c);
    return c + TIME_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid   <= 1'b0;
      tx_kind    <= MSG_DATA;
      tx_payload <= '0;
    end else begin
      tx_valid   <= rx_valid;
      tx_kind    <= rx_kind;
      tx_payload <= enum_hit ? next_count(rx_payload) : rx_payload;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_id   <= '0;
      id_valid <= 1'b0;
    end else if (enum_hit) begin
      dev_id   <= rx_payload[ID_W-1:0];
      id_valid <= 1'b1;
    end
  end

  // R3
  enum_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enum_hit |=> (tx_valid && tx_payload == $past(rx_payload) + TIME_W'(1)));

  // R2
  id_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(id_valid));

endmodule

// File: rtl/sync_offset_calc.sv
module sync_offset_calc
  import tsync_pkg::*;
#(
  parameter int TIME_W   = 32,
  parameter int ID_W     = 6,
  parameter int BASE_DLY = 40,
  parameter int NODE_DLY = 12,
  parameter int THRESH   = 16,
  parameter int OFF_W    = 7
) (
  input  logic                    rx_valid,
  input  logic [1:0]              rx_kind,
  input  logic [TIME_W-1:0]       rx_payload,
  input  logic [ID_W-1:0]         dev_id,
  input  logic                    id_valid,
  input  logic [TIME_W-1:0]       local_time,
  output logic                    sync_evt,
  output logic                    load_evt,
  output logic [TIME_W-1:0]       expected_time,
  output logic signed [OFF_W-1:0] small_off
);

  localparam logic signed [TIME_W-1:0] THR_POS = TIME_W'(THRESH);
  localparam logic signed [TIME_W-1:0] THR_NEG = -THR_POS;

  // Propagation plus accumulated pass-through up to this node.
  function automatic logic [TIME_W-1:0] path_delay(input logic [ID_W-1:0] id);
    return TIME_W'(BASE_DLY) + TIME_W'(NODE_DLY) * TIME_W'(id);
  endfunction

  // Signed distance a - b on a wrapping counter.
  function automatic logic signed [TIME_W-1:0] wrap_gap(input logic [TIME_W-1:0] a,
                                                        input logic [TIME_W-1:0] b);
    return $signed(a - b);
  endfunction

  logic signed [TIME_W-1:0] full_off;
  logic                     too_far;

  always_comb begin
    sync_evt      = rx_valid && (rx_kind == MSG_SYNC) && id_valid;
    expected_time = rx_payload + path_delay(dev_id);
    full_off      = wrap_gap(expected_time, local_time);
    too_far       = (full_off > THR_POS) || (full_off < THR_NEG);
    load_evt      = sync_evt && too_far;
    small_off     = too_far ? '0 : OFF_W'(full_off);
  end

endmodule

// File: rtl/clock_servo.sv
module clock_servo
  import tsync_pkg::*;
#(
  parameter int TIME_W   = 32,
  parameter int OFF_W    = 7,
  parameter int SLEW_GAP = 64,
  parameter int PERIOD   = 10000,
  parameter int MAX_TRIM = 100
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sync_evt,
  input  logic                    load_evt,
  input  logic [TIME_W-1:0]       expected_time,
  input  logic signed [OFF_W-1:0] small_off,
  output logic [TIME_W-1:0]       local_time
);

  localparam int GAP_W   = $clog2(SLEW_GAP + 1);
  localparam int ACC_W   = $clog2(PERIOD) + 1;
  localparam int DRIFT_W = $clog2(MAX_TRIM + 1) + 1;
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(SLEW_GAP - 1);

  logic [TIME_W-1:0]        lt_q, lt_d;
  logic signed [OFF_W-1:0]  pend_q, pend_d;
  logic [GAP_W-1:0]         gap_q, gap_d;
  logic signed [DRIFT_W-1:0] drift_q, drift_d;
  logic [ACC_W-1:0]         acc_q, acc_d;

  // Named correction events, visible to the assertions.
  logic slew_fire, slew_up, slew_dn;
  logic trim_fire, trim_up, trim_dn;

  int dmag, acc_sum, dsum;

  always_comb begin
    slew_fire = !sync_evt && (pend_q != 0) && (gap_q == GAP_LAST);
    slew_up   = slew_fire && !pend_q[OFF_W-1];
    slew_dn   = slew_fire &&  pend_q[OFF_W-1];

    dmag      = (drift_q < 0) ? -int'(drift_q) : int'(drift_q);
    acc_sum   = int'(acc_q) + dmag;
    trim_fire = !sync_evt && (dmag != 0) && (acc_sum >= PERIOD);
    trim_up   = trim_fire && !drift_q[DRIFT_W-1];
    trim_dn   = trim_fire &&  drift_q[DRIFT_W-1];

    dsum      = clamp_sym(int'(drift_q) + int'(small_off), MAX_TRIM);
  end

  always_comb begin
    lt_d = lt_q + TIME_W'(1) + TIME_W'(slew_up) + TIME_W'(trim_up)
                - TIME_W'(slew_dn) - TIME_W'(trim_dn);
    pend_d  = pend_q;
    gap_d   = gap_q;
    drift_d = drift_q;
    acc_d   = acc_q;
    if (sync_evt) begin
      gap_d = '0;
      acc_d = '0;
      if (load_evt) begin
        lt_d   = expected_time + TIME_W'(1);
        pend_d = '0;
      end else begin
        lt_d    = lt_q + TIME_W'(1);
        pend_d  = small_off;
        drift_d = DRIFT_W'(dsum);
      end
    end else begin
      if (pend_q == 0)           gap_d = '0;
      else if (gap_q == GAP_LAST) gap_d = '0;
      else                       gap_d = gap_q + GAP_W'(1);
      if (slew_up)      pend_d = pend_q - OFF_W'(1);
      else if (slew_dn) pend_d = pend_q + OFF_W'(1);
      acc_d = trim_fire ? ACC_W'(acc_sum - PERIOD) : ACC_W'(acc_sum);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lt_q    <= '0;
      pend_q  <= '0;
      gap_q   <= '0;
      drift_q <= '0;
      acc_q   <= '0;
    end else begin
      lt_q    <= lt_d;
      pend_q  <= pend_d;
      gap_q   <= gap_d;
      drift_q <= drift_d;
      acc_q   <= acc_d;
    end
  end

  assign local_time = lt_q;

  // R5
  load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (lt_q == $past(expected_time) + TIME_W'(1)));

  // R4
  free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_evt && pend_q == 0 && drift_q == 0) |=> (lt_q == $past(lt_q) + TIME_W'(1)));

  // R6
  slew_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_evt && pend_q > 0) |=> (pend_q >= 0 && pend_q <= $past(pend_q)));

  // R6
  slew_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_evt && pend_q < 0) |=> (pend_q <= 0 && pend_q >= $past(pend_q)));

  // R7
  trim_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trim_up, trim_dn, sync_evt}));

endmodule

// File: rtl/sync_watch.sv
module sync_watch #(
  parameter int PERIOD       = 10000,
  parameter int LOSS_PERIODS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_evt,
  output logic in_sync
);

  localparam int LIMIT = LOSS_PERIODS * PERIOD;
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             expire;

  assign expire = in_sync && !sync_evt && (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_sync <= 1'b0;
      cnt_q   <= '0;
    end else if (sync_evt) begin
      in_sync <= 1'b1;
      cnt_q   <= '0;
    end else if (expire) begin
      in_sync <= 1'b0;
      cnt_q   <= '0;
    end else if (in_sync) begin
      cnt_q   <= cnt_q + CNT_W'(1);
    end
  end

  // R9
  loss_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_sync) |-> !$past(sync_evt));

  // R9
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_evt |=> in_sync);

endmodule

// File: rtl/slave_time_align.sv
module slave_time_align
  import tsync_pkg::*;
#(
  parameter int TIME_W       = 32,
  parameter int ID_W         = 6,
  parameter int BASE_DLY     = 40,
  parameter int NODE_DLY     = 12,
  parameter int THRESH       = 16,
  parameter int SLEW_GAP     = 64,
  parameter int PERIOD       = 10000,
  parameter int MAX_TRIM     = 100,
  parameter int LOSS_PERIODS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [1:0]        rx_kind,
  input  logic [TIME_W-1:0] rx_payload,
  output logic              tx_valid,
  output logic [1:0]        tx_kind,
  output logic [TIME_W-1:0] tx_payload,
  output logic [TIME_W-1:0] local_time,
  output logic [ID_W-1:0]   dev_id,
  output logic              dev_id_valid,
  output logic              in_sync
);

  localparam int OFF_W = $clog2(THRESH + 1) + 2;

  logic                    sync_evt;
  logic                    load_evt;
  logic [TIME_W-1:0]       expected_time;
  logic signed [OFF_W-1:0] small_off;

  ring_fwd_stage #(.TIME_W(TIME_W), .ID_W(ID_W)) u_fwd (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_kind    (rx_kind),
    .rx_payload (rx_payload),
    .tx_valid   (tx_valid),
    .tx_kind    (tx_kind),
    .tx_payload (tx_payload),
    .dev_id     (dev_id),
    .id_valid   (dev_id_valid)
  );

  sync_offset_calc #(
    .TIME_W(TIME_W), .ID_W(ID_W), .BASE_DLY(BASE_DLY),
    .NODE_DLY(NODE_DLY), .THRESH(THRESH), .OFF_W(OFF_W)
  ) u_off (
    .rx_valid      (rx_valid),
    .rx_kind       (rx_kind),
    .rx_payload    (rx_payload),
    .dev_id        (dev_id),
    .id_valid      (dev_id_valid),
    .local_time    (local_time),
    .sync_evt      (sync_evt),
    .load_evt      (load_evt),
    .expected_time (expected_time),
    .small_off     (small_off)
  );

  clock_servo #(
    .TIME_W(TIME_W), .OFF_W(OFF_W), .SLEW_GAP(SLEW_GAP),
    .PERIOD(PERIOD), .MAX_TRIM(MAX_TRIM)
  ) u_servo (
    .clk           (clk),
    .rst_n         (rst_n),
    .sync_evt      (sync_evt),
    .load_evt      (load_evt),
    .expected_time (expected_time),
    .small_off     (small_off),
    .local_time    (local_time)
  );

  sync_watch #(.PERIOD(PERIOD), .LOSS_PERIODS(LOSS_PERIODS)) u_watch (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_evt (sync_evt),
    .in_sync  (in_sync)
  );

  // R8
  early_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_id_valid |-> !sync_evt);

endmodule

// File: tb/sim_slave_time_align.sv
module sim_slave_time_align;

  localparam int CLK_PERIOD = 10;
  localparam int TW   = 32;
  localparam int IDW  = 6;
  localparam int BASE = 5;
  localparam int NODE = 3;
  localparam int THR  = 8;
  localparam int GAP  = 4;
  localparam int PER  = 200;
  localparam int MAXT = 50;
  localparam int LOSS = 4;
  localparam longint MASK = (64'sd1 <<< TW) - 1;
  localparam longint HALF = 64'sd1 <<< (TW - 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_valid = 1'b0;
  logic [1:0]    rx_kind = 2'd0;
  logic [TW-1:0] rx_payload = '0;
  logic          tx_valid;
  logic [1:0]    tx_kind;
  logic [TW-1:0] tx_payload;
  logic [TW-1:0] local_time;
  logic [IDW-1:0] dev_id;
  logic          dev_id_valid;
  logic          in_sync;

  slave_time_align #(
    .TIME_W(TW), .ID_W(IDW), .BASE_DLY(BASE), .NODE_DLY(NODE), .THRESH(THR),
    .SLEW_GAP(GAP), .PERIOD(PER), .MAX_TRIM(MAXT), .LOSS_PERIODS(LOSS)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_kind(rx_kind),
    .rx_payload(rx_payload), .tx_valid(tx_valid), .tx_kind(tx_kind),
    .tx_payload(tx_payload), .local_time(local_time), .dev_id(dev_id),
    .dev_id_valid(dev_id_valid), .in_sync(in_sync)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  bit cmp_en = 1'b0;

  task automatic chk(input string req, input longint got, input longint exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  longint m_lt = 0, m_pend = 0, m_gap = 0, m_drift = 0, m_acc = 0, m_id = 0, m_cnt = 0;
  longint m_txk = 0, m_txp = 0;
  bit     m_idv = 0, m_ins = 0, m_txv = 0;
  longint e_t, e_off, a_s, a_t, mag, sm;
  bit     e_syn, e_big;

  function automatic longint to_signed(input longint v);
    longint w = v & MASK;
    if (w >= HALF) w = w - (MASK + 1);
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lt = 0; m_pend = 0; m_gap = 0; m_drift = 0; m_acc = 0; m_id = 0; m_cnt = 0;
      m_idv = 0; m_ins = 0; m_txv = 0; m_txk = 0; m_txp = 0;
    end else begin
      e_syn = rx_valid && rx_kind == 2'd2 && m_idv;
      e_t   = (longint'(rx_payload) + BASE + NODE * m_id) & MASK;
      e_off = to_signed(e_t - m_lt);
      e_big = e_off > THR || e_off < -THR;
      if (e_syn) begin
        m_acc = 0; m_gap = 0; m_cnt = 0; m_ins = 1;
        if (e_big) begin
          m_lt = (e_t + 1) & MASK; m_pend = 0;
        end else begin
          m_lt = (m_lt + 1) & MASK; m_pend = e_off;
          m_drift = m_drift + e_off;
          if (m_drift > MAXT) m_drift = MAXT;
          if (m_drift < -MAXT) m_drift = -MAXT;
        end
      end else begin
        a_s = 0; a_t = 0;
        if (m_pend != 0 && m_gap == GAP - 1) a_s = (m_pend > 0) ? 1 : -1;
        mag = (m_drift < 0) ? -m_drift : m_drift;
        sm  = m_acc + mag;
        if (mag != 0 && sm >= PER) begin
          a_t = (m_drift > 0) ? 1 : -1; m_acc = sm - PER;
        end else m_acc = sm;
        if (m_pend != 0) m_gap = (m_gap == GAP - 1) ? 0 : m_gap + 1;
        else m_gap = 0;
        m_pend = m_pend - a_s;
        m_lt = (m_lt + 1 + a_s + a_t) & MASK;
        if (m_ins) begin
          if (m_cnt == LOSS * PER - 1) begin m_ins = 0; m_cnt = 0; end
          else m_cnt = m_cnt + 1;
        end
      end
      if (rx_valid && rx_kind == 2'd1) begin
        m_id = longint'(rx_payload) & ((64'sd1 <<< IDW) - 1); m_idv = 1;
      end
      m_txv = rx_valid;
      m_txk = rx_kind;
      m_txp = (rx_kind == 2'd1) ? ((longint'(rx_payload) + 1) & MASK) : longint'(rx_payload);
    end
  end

  // Per-cycle comparison, away from the rising edge.
  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      chk("R4 local_time vs model", local_time, m_lt);
      chk("R2 dev_id vs model", dev_id, m_id);
      chk("R2 dev_id_valid vs model", dev_id_valid, m_idv);
      chk("R3 tx_valid vs model", tx_valid, m_txv);
      if (m_txv) begin
        chk("R3 tx_kind vs model", tx_kind, m_txk);
        chk("R3 tx_payload vs model", tx_payload, m_txp);
      end
      chk("R9 in_sync vs model", in_sync, m_ins);
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] k, input longint p);
    rx_valid   = 1'b1;
    rx_kind    = k;
    rx_payload = TW'(p & MASK);
    @(negedge clk);
    rx_valid   = 1'b0;
    rx_kind    = 2'd0;
  endtask

  // Time message giving an offset of d at this node; returns local_time seen before it.
  task automatic sync_off(input longint d, output longint l_before);
    l_before = local_time;
    send(2'd2, l_before + d - BASE - NODE * longint'(dev_id));
  endtask

  longint lv;

  initial begin
    idle(3);
    chk("R1 reset local_time", local_time, 0);
    chk("R1 reset tx_valid", tx_valid, 0);
    chk("R1 reset dev_id_valid", dev_id_valid, 0);
    chk("R1 reset in_sync", in_sync, 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    idle(5);
    chk("R4 free run after reset", local_time, 5);

    // R10: plain data only forwarded
    lv = local_time;
    send(2'd0, 64'hABCD1234);
    chk("R10 data forwarded payload", tx_payload, 64'hABCD1234);
    chk("R10 data kind", tx_kind, 0);
    chk("R10 time untouched", local_time, lv + 1);
    chk("R10 no id", dev_id_valid, 0);
    send(2'd3, 64'h55);
    chk("R10 aux forwarded", tx_payload, 64'h55);

    // R8: time message before enumeration
    lv = local_time;
    send(2'd2, lv + 1000);
    chk("R8 early sync no load", local_time, lv + 1);
    chk("R8 early sync no lock", in_sync, 0);

    // R2/R3: enumeration
    send(2'd1, 7);
    chk("R2 dev_id claimed", dev_id, 7);
    chk("R2 dev_id_valid set", dev_id_valid, 1);
    chk("R3 enum count forwarded +1", tx_payload, 8);

    // R5: large offset loads
    sync_off(100, lv);
    chk("R5 load forward", local_time, (lv + 101) & MASK);
    chk("R9 lock after sync", in_sync, 1);
    idle(10);
    sync_off(-(THR + 1), lv);
    chk("R5 load backward at THRESH+1", local_time, (lv - THR) & MASK);

    // R6: offset exactly THRESH is slewed
    sync_off(THR, lv);
    chk("R6 small offset single step", local_time, (lv + 1) & MASK);
    idle(GAP - 1);
    chk("R6 no slew before gap", local_time, (lv + GAP) & MASK);
    idle(1);
    chk("R6 first slew tick on gap edge", local_time, (lv + GAP + 2) & MASK);
    idle(40);

    // R7: learn negative then positive trim
    for (int i = 0; i < 3; i++) begin
      sync_off(-2, lv);
      idle(PER / 2);
    end
    for (int i = 0; i < 20; i++) begin
      sync_off(3, lv);
      idle(PER - 1);
    end
    sync_off(0, lv);
    idle(PER);
    chk("R7 saturated trim over one period", local_time, (lv + 1 + PER + MAXT) & MASK);

    // R9: loss window
    idle(LOSS * PER - PER - 1);
    chk("R9 still locked before window end", in_sync, 1);
    idle(1);
    chk("R9 lock dropped at window end", in_sync, 0);

    // R3/R2: enumeration counter wrap
    send(2'd1, MASK);
    chk("R3 enum wrap", tx_payload, 0);
    chk("R2 dev_id overwritten", dev_id, (64'sd1 <<< IDW) - 1);
    idle(3);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule